// File: doc/BRIEF.md
# Segment-based memory protection unit

This block decides whether a memory access is allowed and which cache policy applies to it. It does not translate: the physical address always equals the virtual address. A foreground table of programmable segments is searched first. Each segment has a start address, a 13-bit attribute and an enable bit. If no single enabled foreground segment covers the address, a fixed background table, set by parameters, supplies the attribute instead.

Software programs the foreground table through an entry-write port and a whole-mask write port. It can read entries back and can probe an address to see which table entry would govern it. A separate access-check port takes an address, an access kind and a privilege ring. One cycle after the check strobe it returns a registered verdict, a fault cause and a cache policy. Whenever the protection state is altered, a flush pulse tells downstream caches of translations to drop what they hold.

Top module: `mpu_guard`

## Requirements
- R1: Foreground segment j covers address A when A >= start[j] and, unless j is the last segment, A < start[j+1]; segment starts are compared as unsigned 32-bit values.
- R2: If two or more foreground segments cover the address, the check reports cause 1 for a load or store and cause 2 for a fetch. A probe of such an address raises probe_fault and returns 0.
- R3: A single covering foreground segment governs only when its enable bit is set. Otherwise the background entry covering the address governs. The background entries are ordered by start, and the first starts at 0.
- R4: An entry write takes the segment number from wr_data[4:0] and the attribute from wr_data[20:8]. It stores wr_addr rounded down to 2^ALIGN_LOG2 as the start, copies wr_addr[0] into that segment's enable bit, and pulses flush the next cycle. A write to a segment number >= SEGS changes nothing and gives no flush.
- R5: A mask write keeps only the low SEGS bits of wr_mask_data, and flush pulses the next cycle only if the mask changed. After reset the mask, all starts and all attributes are 0, and cfg_segs reads SEGS. If an entry write and a mask write fall in the same cycle, the entry write decides its own segment's enable bit.
- R6: For an in-range rd_sel[4:0], rd_word0 returns start | enable bit and rd_word1 returns attribute << 8. For an out-of-range selector, both words read 0.
- R7: For an enabled single foreground hit, the probe returns bit 31 | attribute << 8 | segment number. Otherwise it returns bit 30 | background attribute << 8.
- R8: In ring 0, rights value (attribute bits 3:0) 4..15 grants R, RX, RW, RWX, W, RW, RW, RWX, R, RX, RW, RWX, and 0..3 grant nothing.
- R9: In rings 1..3, rights 8..15 grant W, RWX, R, RX, R, RX, RW, RWX, and 0..7 grant nothing.
- R10: chk_kind 0 is a load, 1 is a store, and 2 or 3 is a fetch. A load needs R, a store needs W and a fetch needs X. A denied access gives cause 3 for a load, 4 for a store and 5 for a fetch, with res_ok low and res_paddr 0.
- R11: A granted access gives res_ok high, cause 0 and res_paddr equal to chk_addr. res_page_size is always 2^ALIGN_LOG2.
- R12: The cache policy comes from the memory-type field T = attribute bits 12:4. T is cacheable when T[8:7]=11, or when T[8:7]=01 and either T[3]=0 or T[3:0]=1001. Cacheable T with T[4]=1 gives 2 (write-back), cacheable T with T[4]=0 gives 1 (write-through), and any other T gives 0 (bypass). res_cache is 0 on a fault.
- R13: res_valid is high exactly in the cycle after a chk_valid cycle, and the result fields then hold the verdict for that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_entry_en | input | 1 | Write one segment entry |
| wr_data | input | 32 | Segment number [4:0] and attribute [20:8] |
| wr_addr | input | 32 | Segment start; bit 0 is the enable bit |
| wr_mask_en | input | 1 | Write the whole enable mask |
| wr_mask_data | input | 32 | New enable mask |
| rd_sel | input | 32 | Segment selector for reads, bits [4:0] |
| rd_word0 | output | 32 | Start address with the enable bit |
| rd_word1 | output | 32 | Attribute shifted to bits 20:8 |
| cfg_segs | output | 32 | Number of foreground segments |
| probe_addr | input | 32 | Address to probe |
| probe_result | output | 32 | Encoded probe answer |
| probe_fault | output | 1 | Probe found overlapping segments |
| chk_valid | input | 1 | Access-check strobe |
| chk_addr | input | 32 | Access address |
| chk_kind | input | 2 | 0 load, 1 store, 2/3 fetch |
| chk_ring | input | 2 | Privilege ring, 0 most privileged |
| res_valid | output | 1 | Result valid for the previous strobe |
| res_ok | output | 1 | Access granted |
| res_cause | output | 4 | Fault cause, 0 when granted |
| res_paddr | output | 32 | Physical address when granted |
| res_cache | output | 2 | 0 bypass, 1 write-through, 2 write-back |
| res_page_size | output | 32 | Protection granule size in bytes |
| flush | output | 1 | One-cycle pulse after a state change |

## Verification
Reads and probes are combinational on the current table. The bench drives them on a falling edge and samples them 1 ns later. An access result is due one rising edge after its strobe, and so is a flush pulse after a write. The bench raises each such stimulus on a falling edge, lowers it on the next falling edge, and samples the registered output at that second falling edge, which lies half a period after the capturing edge. In the same cycle it also compares the flush level with what the write should have caused, so a missing pulse and a spurious pulse are both caught.

// File: rtl/mpu_guard.sv
module mpu_guard #(
  parameter int SEGS = 16,
  parameter int ALIGN_LOG2 = 12,
  parameter int BG_N = 2,
  parameter logic [BG_N*32-1:0] BG_START = {32'h8000_0000, 32'h0000_0000},
  parameter logic [BG_N*13-1:0] BG_ATTR = {13'h000F, 13'h1907}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_entry_en,
  input  logic [31:0] wr_data,
  input  logic [31:0] wr_addr,
  input  logic        wr_mask_en,
  input  logic [31:0] wr_mask_data,
  input  logic [31:0] rd_sel,
  output logic [31:0] rd_word0,
  output logic [31:0] rd_word1,
  output logic [31:0] cfg_segs,
  input  logic [31:0] probe_addr,
  output logic [31:0] probe_result,
  output logic        probe_fault,
  input  logic        chk_valid,
  input  logic [31:0] chk_addr,
  input  logic [1:0]  chk_kind,
  input  logic [1:0]  chk_ring,
  output logic        res_valid,
  output logic        res_ok,
  output logic [3:0]  res_cause,
  output logic [31:0] res_paddr,
  output logic [1:0]  res_cache,
  output logic [31:0] res_page_size,
  output logic        flush
);
  localparam int IW = (SEGS > 1) ? $clog2(SEGS) : 1;
  localparam int BIW = (BG_N > 1) ? $clog2(BG_N) : 1;
  localparam logic [31:0] GRAN = 32'd1 << ALIGN_LOG2;
  localparam logic [31:0] ALIGN_MASK = ~(GRAN - 32'd1);

  logic [31:0] seg_start [SEGS];
  logic [12:0] seg_attr [SEGS];
  logic [SEGS-1:0] en_mask;

  function automatic logic [2:0] rights_xwr(input logic [3:0] r, input logic user);
    logic [2:0] p;
    p = 3'b000;
    if (!user) begin
      case (r)
        4'd4, 4'd12:               p = 3'b001;
        4'd5, 4'd13:               p = 3'b101;
        4'd6, 4'd9, 4'd10, 4'd14:  p = 3'b011;
        4'd7, 4'd11, 4'd15:        p = 3'b111;
        4'd8:                      p = 3'b010;
        default:                   p = 3'b000;
      endcase
    end else begin
      case (r)
        4'd8:          p = 3'b010;
        4'd9, 4'd15:   p = 3'b111;
        4'd10, 4'd12:  p = 3'b001;
        4'd11, 4'd13:  p = 3'b101;
        4'd14:         p = 3'b011;
        default:       p = 3'b000;
      endcase
    end
    return p;
  endfunction

  function automatic logic [1:0] cache_policy(input logic [8:0] t);
    logic hit;
    hit = ((t & 9'h18F) == 9'h089) || ((t & 9'h188) == 9'h080) ||
          ((t & 9'h180) == 9'h180);
    return hit ? (t[4] ? 2'd2 : 2'd1) : 2'd0;
  endfunction

  for (genvar p = 0; p < 2; p++) begin : g_lk
    logic [31:0] a;
    logic [SEGS-1:0] hits;
    logic [IW-1:0] first;
    logic [BIW-1:0] bsel;
    logic multi;
    logic use_fg;
    logic [12:0] attr;

    assign a = (p == 0) ? probe_addr : chk_addr;

    always_comb begin
      hits = '0;
      first = '0;
      for (int j = 0; j < SEGS; j++) begin
        hits[j] = (a >= seg_start[j]) &&
                  ((j == SEGS - 1) || (a < seg_start[(j + 1) % SEGS]));
      end
      for (int j = SEGS - 1; j >= 0; j--) begin
        if (hits[j]) first = IW'(j);
      end
    end

    always_comb begin
      bsel = '0;
      for (int j = BG_N - 1; j >= 0; j--) begin
        if ((a >= BG_START[j*32 +: 32]) &&
            ((j == BG_N - 1) || (a < BG_START[((j + 1) % BG_N)*32 +: 32])))
          bsel = BIW'(j);
      end
    end

    assign multi = |(hits & (hits - SEGS'(1)));
    assign use_fg = (hits != '0) && !multi && en_mask[first];
    assign attr = use_fg ? seg_attr[first] : BG_ATTR[bsel*13 +: 13];
  end

  always_comb begin
    if (g_lk[0].multi)
      probe_result = 32'd0;
    else if (g_lk[0].use_fg)
      probe_result = {1'b1, 10'd0, g_lk[0].attr, 3'd0, 5'(g_lk[0].first)};
    else
      probe_result = {1'b0, 1'b1, 9'd0, g_lk[0].attr, 8'd0};
  end
  assign probe_fault = g_lk[0].multi;

  logic rd_in;
  logic [IW-1:0] rd_idx;
  assign rd_in = rd_sel[4:0] < SEGS;
  assign rd_idx = rd_sel[IW-1:0];
  assign rd_word0 = rd_in ? (seg_start[rd_idx] | {31'd0, en_mask[rd_idx]}) : 32'd0;
  assign rd_word1 = rd_in ? {11'd0, seg_attr[rd_idx], 8'd0} : 32'd0;
  assign cfg_segs = 32'(SEGS);
  assign res_page_size = GRAN;

  logic is_fetch, is_store, granted;
  logic [2:0] perm;
  logic [3:0] cause;
  assign is_fetch = chk_kind[1];
  assign is_store = (chk_kind == 2'b01);
  assign perm = rights_xwr(g_lk[1].attr[3:0], chk_ring != 2'd0);
  assign granted = is_fetch ? perm[2] : (is_store ? perm[1] : perm[0]);

  always_comb begin
    if (g_lk[1].multi)
      cause = is_fetch ? 4'd2 : 4'd1;
    else if (!granted)
      cause = is_fetch ? 4'd5 : (is_store ? 4'd4 : 4'd3);
    else
      cause = 4'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_ok <= 1'b0;
      res_cause <= 4'd0;
      res_paddr <= 32'd0;
      res_cache <= 2'd0;
    end else begin
      res_valid <= chk_valid;
      if (chk_valid) begin
        res_ok <= (cause == 4'd0);
        res_cause <= cause;
        res_paddr <= (cause == 4'd0) ? chk_addr : 32'd0;
        res_cache <= (cause == 4'd0) ? cache_policy(g_lk[1].attr[12:4]) : 2'd0;
      end
    end
  end

  logic wr_in;
  logic [IW-1:0] wr_idx;
  assign wr_in = wr_data[4:0] < SEGS;
  assign wr_idx = wr_data[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < SEGS; j++) begin
        seg_start[j] <= 32'd0;
        seg_attr[j] <= 13'd0;
      end
      en_mask <= '0;
      flush <= 1'b0;
    end else begin
      flush <= 1'b0;
      if (wr_mask_en) begin
        en_mask <= wr_mask_data[SEGS-1:0];
        if (wr_mask_data[SEGS-1:0] != en_mask) flush <= 1'b1;
      end
      if (wr_entry_en && wr_in) begin
        seg_start[wr_idx] <= wr_addr & ALIGN_MASK;
        seg_attr[wr_idx] <= wr_data[20:8];
        en_mask[wr_idx] <= wr_addr[0];
        flush <= 1'b1;
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{wr_data, wr_mask_data, rd_sel};
endmodule

// File: rtl/mpu_guard_chk.sv
module mpu_guard_chk #(
  parameter int SEGS = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        chk_valid,
  input logic [31:0] chk_addr,
  input logic        res_valid,
  input logic        res_ok,
  input logic [3:0]  res_cause,
  input logic [31:0] res_paddr,
  input logic        wr_entry_en,
  input logic [31:0] wr_data,
  input logic        wr_mask_en,
  input logic        flush,
  input logic [31:0] probe_result,
  input logic        probe_fault,
  input logic [31:0] rd_sel,
  input logic [31:0] rd_word0,
  input logic [31:0] rd_word1
);
  AST_RES_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) chk_valid |=> res_valid); // R13
  AST_RES_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> $past(chk_valid)); // R13
  AST_GRANT_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ok) |-> (res_cause == 4'd0 && res_paddr == $past(chk_addr))); // R11
  AST_DENY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ok) |-> (res_cause != 4'd0 && res_paddr == 32'd0)); // R10
  AST_ENTRY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_entry_en && wr_data[4:0] < SEGS) |=> flush); // R4
  AST_FLUSH_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(wr_entry_en || wr_mask_en)); // R5
  AST_PROBE_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    probe_fault |-> probe_result == 32'd0); // R2
  AST_PROBE_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !probe_fault |-> $countones(probe_result[31:30]) == 1); // R7
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel[4:0] >= SEGS) |-> (rd_word0 == 32'd0 && rd_word1 == 32'd0)); // R6
endmodule

bind mpu_guard mpu_guard_chk #(.SEGS(SEGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_addr(chk_addr),
  .res_valid(res_valid), .res_ok(res_ok), .res_cause(res_cause), .res_paddr(res_paddr),
  .wr_entry_en(wr_entry_en), .wr_data(wr_data), .wr_mask_en(wr_mask_en), .flush(flush),
  .probe_result(probe_result), .probe_fault(probe_fault),
  .rd_sel(rd_sel), .rd_word0(rd_word0), .rd_word1(rd_word1)
);

// File: tb/test_mpu_guard.sv
module test_mpu_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam logic [12:0] BG0 = 13'h1907;
  localparam logic [12:0] BG1 = 13'h000F;

  logic clk = 0, rst_n = 0;
  logic wr_entry_en = 0, wr_mask_en = 0, chk_valid = 0;
  logic [31:0] wr_data = 0, wr_addr = 0, wr_mask_data = 0, rd_sel = 0, probe_addr = 0, chk_addr = 0;
  logic [1:0] chk_kind = 0, chk_ring = 0;
  logic [31:0] rd_word0, rd_word1, cfg_segs, probe_result, res_paddr, res_page_size;
  logic probe_fault, res_valid, res_ok, flush;
  logic [3:0] res_cause;
  logic [1:0] res_cache;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  bit [31:0] m_start [NS];
  bit [12:0] m_attr [NS];
  bit [NS-1:0] m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpu_guard #(.SEGS(NS)) i_mpu_guard (
    .clk(clk), .rst_n(rst_n), .wr_entry_en(wr_entry_en), .wr_data(wr_data), .wr_addr(wr_addr),
    .wr_mask_en(wr_mask_en), .wr_mask_data(wr_mask_data), .rd_sel(rd_sel), .rd_word0(rd_word0),
    .rd_word1(rd_word1), .cfg_segs(cfg_segs), .probe_addr(probe_addr), .probe_result(probe_result),
    .probe_fault(probe_fault), .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_kind(chk_kind),
    .chk_ring(chk_ring), .res_valid(res_valid), .res_ok(res_ok), .res_cause(res_cause),
    .res_paddr(res_paddr), .res_cache(res_cache), .res_page_size(res_page_size), .flush(flush)
  );

  task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void lookup(input logic [31:0] a, output bit multi, output bit fg,
                                 output int seg, output logic [12:0] at);
    int n = 0;
    seg = 0;
    for (int j = 0; j < NS; j++) begin
      if (a >= m_start[j] && (j == NS - 1 || a < m_start[(j + 1) % NS])) begin
        if (n == 0) seg = j;
        n++;
      end
    end
    multi = (n > 1);
    fg = (n == 1) && m_en[seg];
    at = fg ? m_attr[seg] : (a >= 32'h8000_0000 ? BG1 : BG0);
  endfunction

  // returns {X,W,R}
  function automatic logic [2:0] exp_perm(input logic [3:0] r, input int ring);
    if (ring == 0) begin
      if (r < 4) return 3'b000;
      case (r)
        4: return 3'b001;  5: return 3'b101;  6: return 3'b011;  7: return 3'b111;
        8: return 3'b010;  9: return 3'b011; 10: return 3'b011; 11: return 3'b111;
        12: return 3'b001; 13: return 3'b101; 14: return 3'b011; default: return 3'b111;
      endcase
    end
    if (r < 8) return 3'b000;
    case (r)
      8: return 3'b010;  9: return 3'b111; 10: return 3'b001; 11: return 3'b101;
      12: return 3'b001; 13: return 3'b101; 14: return 3'b011; default: return 3'b111;
    endcase
  endfunction

  function automatic logic [1:0] exp_cache(input logic [8:0] t);
    bit c = ({t[8], t[7]} == 2'b11) || ({t[8], t[7]} == 2'b01 && (!t[3] || t[3:0] == 4'h9));
    return c ? (t[4] ? 2'd2 : 2'd1) : 2'd0;
  endfunction

  task automatic write_entry(input int s, input logic [31:0] a, input logic [12:0] at);
    @(negedge clk);
    wr_entry_en = 1; wr_data = {11'd0, at, 3'd0, 5'(s)}; wr_addr = a;
    @(negedge clk);
    wr_entry_en = 0;
    if (s < NS) begin
      m_start[s] = a & 32'hFFFF_F000; m_attr[s] = at; m_en[s] = a[0];
    end
    expect_eq("R4 flush after entry write", 32'(flush), 32'(s < NS));
  endtask

  task automatic write_mask(input logic [31:0] v);
    bit changed = (v[NS-1:0] != m_en);
    @(negedge clk);
    wr_mask_en = 1; wr_mask_data = v;
    @(negedge clk);
    wr_mask_en = 0;
    m_en = v[NS-1:0];
    expect_eq("R5 flush after mask write", 32'(flush), 32'(changed));
  endtask

  task automatic check_reads(input string req);
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      rd_sel = 32'(s); #1;
      if (s < NS) begin
        expect_eq({req, " R6 word0"}, rd_word0, m_start[s] | 32'(m_en[s]));
        expect_eq({req, " R6 word1"}, rd_word1, {11'd0, m_attr[s], 8'd0});
      end else begin
        expect_eq({req, " R6 out-of-range word0"}, rd_word0, 32'd0);
        expect_eq({req, " R6 out-of-range word1"}, rd_word1, 32'd0);
      end
    end
  endtask

  task automatic check_probe(input string req, input logic [31:0] a);
    bit multi, fg; int seg; logic [12:0] at;
    logic [31:0] exp;
    lookup(a, multi, fg, seg, at);
    @(negedge clk);
    probe_addr = a; #1;
    if (multi) exp = 32'd0;
    else if (fg) exp = 32'h8000_0000 | {11'd0, at, 8'd0} | 32'(seg);
    else exp = 32'h4000_0000 | {11'd0, at, 8'd0};
    expect_eq({req, " R7 probe result"}, probe_result, exp);
    expect_eq({req, " R2 probe fault"}, 32'(probe_fault), 32'(multi));
  endtask

  task automatic access(input string req, input logic [31:0] a, input int kind, input int ring);
    bit multi, fg; int seg; logic [12:0] at;
    logic [2:0] pm; bit need, fetch, store; logic [3:0] ec;
    lookup(a, multi, fg, seg, at);
    fetch = (kind >= 2); store = (kind == 1);
    pm = exp_perm(at[3:0], ring);
    need = fetch ? pm[2] : (store ? pm[1] : pm[0]);
    if (multi) ec = fetch ? 4'd2 : 4'd1;
    else if (!need) ec = fetch ? 4'd5 : (store ? 4'd4 : 4'd3);
    else ec = 4'd0;
    @(negedge clk);
    chk_valid = 1; chk_addr = a; chk_kind = 2'(kind); chk_ring = 2'(ring);
    @(negedge clk);
    chk_valid = 0;
    expect_eq({req, " R13 res_valid"}, 32'(res_valid), 32'd1);
    expect_eq({req, " R10 cause"}, 32'(res_cause), 32'(ec));
    expect_eq({req, " R11 ok"}, 32'(res_ok), 32'(ec == 0));
    expect_eq({req, " R11 paddr"}, res_paddr, (ec == 0) ? a : 32'd0);
    expect_eq({req, " R12 cache"}, 32'(res_cache), (ec == 0) ? 32'(exp_cache(at[12:4])) : 32'd0);
  endtask

  initial begin
    for (int j = 0; j < NS; j++) begin m_start[j] = 0; m_attr[j] = 0; end
    m_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_eq("R13 reset res_valid", 32'(res_valid), 0);
    expect_eq("R5 reset flush", 32'(flush), 0);
    expect_eq("R5 cfg_segs", cfg_segs, NS);
    expect_eq("R11 page size", res_page_size, 32'h1000);
    check_reads("reset");
    check_probe("R3 reset low background", 32'h0000_1000);
    check_probe("R3 reset high background", 32'h9000_0000);
    access("R3 reset background ring0", 32'h0000_1234, 0, 0);
    access("R3 reset background ring1", 32'h0000_1234, 0, 1);
    access("R3 high background ring2 fetch", 32'hA000_0000, 2, 2);
    @(negedge clk);
    expect_eq("R13 res_valid drops", 32'(res_valid), 0);

    write_entry(0, 32'h0000_0001, 13'h0007);
    write_entry(1, 32'h0000_1001, 13'h0007);
    write_entry(2, 32'h0000_2001, 13'h0007);
    write_entry(3, 32'h0000_3001, 13'h0007);
    check_reads("ordered table");

    // R8 R9 sweep of rights, rings and kinds
    for (int r = 0; r < 16; r++) begin
      write_entry(1, 32'h0000_1001, 13'(r));
      check_probe("R1 fg hit", 32'h0000_1234);
      for (int ring = 0; ring < 4; ring++)
        for (int k = 0; k < 3; k++)
          access((ring == 0) ? "R8 ring0 rights" : "R9 user rights", 32'h0000_1234, k, ring);
    end

    // R12 memory-type sweep
    for (int t = 0; t < 512; t++) begin
      write_entry(1, 32'h0000_1001, {9'(t), 4'h7});
      access("R12 memtype", 32'h0000_1800, 0, 0);
    end

    // R3 enable gating and R5 mask width
    write_mask(32'h0);
    access("R3 disabled uses background", 32'h0000_1234, 0, 0);
    access("R3 disabled background ring1", 32'h0000_1234, 1, 1);
    check_probe("R3 disabled probe", 32'h0000_1234);
    write_mask(32'hFFFF_FFF5);
    check_reads("R5 mask low bits");
    write_mask(32'h0000_0005);
    check_probe("R3 partially enabled", 32'h0000_1234);
    write_mask(32'h0000_000F);

    // R4 rounding and enable bit
    write_entry(3, 32'h0000_5679, 13'h0ABC);
    @(negedge clk); rd_sel = 3; #1;
    expect_eq("R4 rounded start", rd_word0, 32'h0000_5001);
    expect_eq("R4 attribute", rd_word1, 32'h000A_BC00);
    write_entry(2, 32'h0000_2000, 13'h000F);
    check_probe("R4 enable cleared by bit0", 32'h0000_2100);

    // R4 out-of-range write ignored
    write_entry(5, 32'h0000_7001, 13'h1FFF);
    write_entry(31, 32'h0000_0001, 13'h1FFF);
    check_reads("R4 out-of-range");

    // R2 overlapping segments
    write_entry(2, 32'h0000_0801, 13'h000F);
    check_probe("R2 overlap", 32'h0000_0900);
    access("R2 overlap load", 32'h0000_0900, 0, 0);
    access("R2 overlap store", 32'h0000_0900, 1, 0);
    access("R2 overlap fetch", 32'h0000_0900, 2, 0);
    access("R1 single after overlap", 32'h0000_2000, 2, 1);
    check_probe("R1 last segment", 32'hC000_0000);
    access("R1 last segment", 32'hC000_0000, 1, 3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule